// File: doc/BRIEF.md
# Audio Clock Relationship Watchdog

This block supervises the clocks of a serial audio transmitter. It runs on the master clock. It watches the frame clock and the bit clock, which arrive asynchronously. After power-down is released it waits for a fixed number of bit-clock rising edges and then raises a ready flag. That flag releases the transmitter's framing logic.

Once ready, the block measures where each frame-clock rising edge falls against a free-running master-clock phase counter. The counter wraps at the expected number of master clocks per frame, which the ratio select chooses. The first edge sets a reference. Every later edge adds its signed slip to a running drift sum. When the total drift reaches three base frame lengths, the block emits a one-cycle pulse. The pulse restarts the transmitter's frame and bit counters. The block then takes a fresh reference.

The pulse never touches the ready flag. The transmitter's configuration state therefore stays outside this recovery path and only the counters restart.

Top module: `audio_clk_watchdog`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ready` and `resync_pulse` are 0.
- R2: While `power_down` is high, `ready` is 0. A high `power_down` sampled on a master-clock edge makes `ready` 0 after that same edge.
- R3: After `power_down` falls, `ready` rises once exactly 8 rising edges of `bit_clk` have been seen. Fewer edges leave it low. Each new release of `power_down` restarts the count from zero.
- R4: `ratio_sel` sets the master clocks per frame as follows: 00 gives 128, 01 gives 256, 10 gives 384 and 11 gives 512. The value is taken while `ready` is low and is held once `ready` is high, so later changes have no effect.
- R5: `resync_pulse` never asserts while `ready` is low. The first `frame_clk` rising edge after `ready` rises only sets the reference and never pulses.
- R6: At each later frame edge, the slip is the number of master clocks between this edge and the previous one, taken modulo the frame length and mapped into the range (−L/2, +L/2]. A slip of exactly L/2 counts as positive. The slips are summed with sign, and `resync_pulse` fires when the magnitude of the sum reaches 384.
- R7: `resync_pulse` lasts one cycle. After it fires, the drift sum is cleared and the edge that caused the pulse becomes the new reference, so a further pulse needs another 384 cycles of drift.
- R8: `resync_pulse` never changes `ready`. `ready` stays high as long as `power_down` stays low.
- R9: `frame_clk` passes through a two-flop synchroniser. A pulse caused by a frame edge is high after the third master-clock rising edge that follows the `frame_clk` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| power_down | input | 1 | Power-down request, active high, synchronous to `clk_mclk` |
| frame_clk | input | 1 | Frame clock, asynchronous; rising edges are tracked |
| bit_clk | input | 1 | Bit clock, asynchronous; rising edges are counted during start-up |
| ratio_sel | input | 2 | Master-clock to frame ratio code (00:128, 01:256, 10:384, 11:512) |
| resync_pulse | output | 1 | One-cycle request to restart frame and bit counters |
| ready | output | 1 | Framing logic released |

## Verification
Frames are sent with a constant positive and a constant negative period error for every ratio code. The first pulse has to land on the edge where the drift first reaches 384, so a wrong frame length or a wrong threshold shows up as an early or late pulse. Two further periods test the wrap rule. A slip of +100 at ratio 128 must count as −28, and a slip of exactly half a frame must count as positive. Both give edge numbers that differ from what a naive subtraction would give. Three more patterns must produce no pulse at all: an alternating ±5 jitter, a perfectly locked frame clock, and a ratio change made after ready. These separate a design that accumulates signed drift and freezes its ratio from one that does not.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;

    // Master clocks per frame for ratio code 0; code n gives (n+1) times this.
    localparam int BASE_RATIO  = 128;
    localparam int RATIO_CODES = 4;
    localparam int PH_W        = $clog2(BASE_RATIO * RATIO_CODES);
    localparam int PER_W       = PH_W + 1;
    localparam int ACC_W       = PH_W + 4;

    typedef logic [1:0] ratio_sel_t;

    typedef enum logic {
        MON_ARM   = 1'b0,
        MON_TRACK = 1'b1
    } mon_state_e;

    typedef struct packed {
        logic [PH_W-1:0]         ref_phase;
        logic signed [ACC_W-1:0] drift;
    } track_t;

    function automatic logic [PER_W-1:0] frame_period(input ratio_sel_t sel);
        return PER_W'(BASE_RATIO * (int'(sel) + 1));
    endfunction

    // Circular difference now-prev mapped into (-per/2, +per/2].
    function automatic logic signed [PER_W:0] phase_slip(
        input logic [PH_W-1:0]  now_ph,
        input logic [PH_W-1:0]  prev_ph,
        input logic [PER_W-1:0] per
    );
        logic [PER_W-1:0] d;
        if (now_ph >= prev_ph)
            d = PER_W'(now_ph) - PER_W'(prev_ph);
        else
            d = PER_W'(now_ph) + per - PER_W'(prev_ph);
        if (d > (per >> 1))
            return $signed({1'b0, d}) - $signed({1'b0, per});
        else
            return $signed({1'b0, d});
    endfunction

    function automatic logic [ACC_W-1:0] drift_mag(input logic signed [ACC_W-1:0] v);
        return v[ACC_W-1] ? ACC_W'(-v) : ACC_W'(v);
    endfunction

endpackage

// File: rtl/clkwd_sync.sv
module clkwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else
            shreg <= {shreg[STAGES-1:0], async_in};
    end

    // Edge detected between last synchroniser stage and one extra history flop.
    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/clkwd_init_seq.sv
module clkwd_init_seq #(
    parameter int INIT_BCLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic power_down,
    input  logic bclk_rise,
    output logic ready
);
    localparam int CNT_W = $clog2(INIT_BCLKS + 1);

    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst || power_down) begin
            edge_cnt <= '0;
            ready    <= 1'b0;
        end else if (!ready && bclk_rise) begin
            if (edge_cnt == CNT_W'(INIT_BCLKS - 1)) begin
                edge_cnt <= '0;
                ready    <= 1'b1;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkwd_phase_mon.sv
module clkwd_phase_mon
    import clkwd_pkg::*;
#(
    parameter int THRESH = 3 * BASE_RATIO
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       frame_rise,
    input  ratio_sel_t ratio_sel,
    output logic       resync_pulse
);
    logic [PER_W-1:0]        period_q;
    logic [PH_W-1:0]         phase_cnt;
    mon_state_e              state;
    track_t                  trk;
    logic signed [PER_W:0]   slip;
    logic signed [ACC_W-1:0] drift_next;
    logic                    over;

    always_comb begin
        slip       = phase_slip(phase_cnt, trk.ref_phase, period_q);
        drift_next = trk.drift + ACC_W'(slip);
        over       = drift_mag(drift_next) >= ACC_W'(THRESH);
    end

    // Ratio is followed while idle and frozen for the whole run.
    always_ff @(posedge clk) begin
        if (rst)
            period_q <= frame_period(2'b00);
        else if (!run)
            period_q <= frame_period(ratio_sel);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase_cnt <= '0;
        else if (PER_W'(phase_cnt) == period_q - 1'b1)
            phase_cnt <= '0;
        else
            phase_cnt <= phase_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state        <= MON_ARM;
            trk          <= '0;
            resync_pulse <= 1'b0;
        end else begin
            resync_pulse <= 1'b0;
            if (frame_rise) begin
                trk.ref_phase <= phase_cnt;
                if (state == MON_ARM) begin
                    trk.drift <= '0;
                    state     <= MON_TRACK;
                end else if (over) begin
                    trk.drift    <= '0;
                    resync_pulse <= 1'b1;
                end else begin
                    trk.drift <= drift_next;
                end
            end
        end
    end
endmodule

// File: rtl/audio_clk_watchdog.sv
module audio_clk_watchdog
    import clkwd_pkg::*;
#(
    parameter int INIT_BCLKS  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DRIFT_MULT  = 3
) (
    input  logic       clk_mclk,
    input  logic       rst,
    input  logic       power_down,
    input  logic       frame_clk,
    input  logic       bit_clk,
    input  logic [1:0] ratio_sel,
    output logic       resync_pulse,
    output logic       ready
);
    localparam int THRESH = DRIFT_MULT * BASE_RATIO;

    logic frame_rise;
    logic bclk_rise;
    logic run;

    clkwd_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
        .clk      (clk_mclk),
        .rst      (rst),
        .async_in (frame_clk),
        .rise     (frame_rise)
    );

    clkwd_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
        .clk      (clk_mclk),
        .rst      (rst),
        .async_in (bit_clk),
        .rise     (bclk_rise)
    );

    clkwd_init_seq #(.INIT_BCLKS(INIT_BCLKS)) u_init (
        .clk        (clk_mclk),
        .rst        (rst),
        .power_down (power_down),
        .bclk_rise  (bclk_rise),
        .ready      (ready)
    );

    assign run = ready & ~power_down;

    clkwd_phase_mon #(.THRESH(THRESH)) u_mon (
        .clk          (clk_mclk),
        .rst          (rst),
        .run          (run),
        .frame_rise   (frame_rise),
        .ratio_sel    (ratio_sel),
        .resync_pulse (resync_pulse)
    );
endmodule

// File: rtl/clkwd_checker.sv
module clkwd_checker (
    input logic clk,
    input logic rst,
    input logic power_down,
    input logic resync_pulse,
    input logic ready
);
    p_pd_clears_ready_r2: assert property (@(posedge clk) disable iff (rst)
        power_down |=> !ready);

    p_ready_rise_clean_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> !$past(power_down));

    p_no_pulse_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !resync_pulse);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        resync_pulse |=> !resync_pulse);

    p_ready_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !power_down) |=> ready);
endmodule

bind audio_clk_watchdog clkwd_checker u_chk (
    .clk          (clk_mclk),
    .rst          (rst),
    .power_down   (power_down),
    .resync_pulse (resync_pulse),
    .ready        (ready)
);

// File: tb/audio_clk_watchdog_tb_top.sv
module audio_clk_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [1:0] sel;
        int         ka;
        int         kb;
        int         frames;
        int         exp_first;
        int         exp_count;
    } vec_t;

    // sel, slip on odd frames, slip on even frames, frames, first pulse edge, pulses
    localparam vec_t VECS [NVEC] = '{
        '{2'd0,   8,   8, 52, 49, 1},
        '{2'd0,  -8,  -8, 52, 49, 1},
        '{2'd1,  20,  20, 24, 21, 1},
        '{2'd2, -30, -30, 17, 14, 1},
        '{2'd3,  64,  64, 14,  7, 2},
        '{2'd0, 100, 100, 18, 15, 1},
        '{2'd0,  64,  64, 10,  7, 1},
        '{2'd1,   5,  -5, 40,  0, 0},
        '{2'd0,   0,   0, 20,  0, 0}
    };

    logic       clk_mclk = 1'b0;
    logic       rst = 1'b1;
    logic       power_down = 1'b1;
    logic       frame_clk = 1'b0;
    logic       bit_clk = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       resync_pulse;
    logic       ready;

    int checks = 0;
    int errors = 0;

    audio_clk_watchdog dut_i (
        .clk_mclk     (clk_mclk),
        .rst          (rst),
        .power_down   (power_down),
        .frame_clk    (frame_clk),
        .bit_clk      (bit_clk),
        .ratio_sel    (ratio_sel),
        .resync_pulse (resync_pulse),
        .ready        (ready)
    );

    always #(CLK_PERIOD / 2) clk_mclk = ~clk_mclk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_mclk);
    endtask

    task automatic bclk_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_mclk) bit_clk = 1'b1;
            cycles(2);
            bit_clk = 1'b0;
            cycles(2);
        end
    endtask

    task automatic bring_up(input logic [1:0] sel);
        @(negedge clk_mclk);
        power_down = 1'b1;
        ratio_sel  = sel;
        cycles(3);
        power_down = 1'b0;
        bclk_pulses(7);
        cycles(6);
        check("R3", "ready after 7 bit clocks", int'(ready), 0);
        bclk_pulses(1);
        cycles(6);
        check("R3", "ready after 8 bit clocks", int'(ready), 1);
    endtask

    // Sends frames; frame f lasts per + (odd f ? ka : kb) cycles.
    task automatic run_frames(input int per, input int ka, input int kb, input int frames,
                              output int first_edge, output int count, output int lat);
        first_edge = 0;
        count = 0;
        lat = -1;
        for (int f = 1; f <= frames; f++) begin
            int len;
            len = per + (((f % 2) == 1) ? ka : kb);
            for (int c = 0; c < len; c++) begin
                @(negedge clk_mclk);
                frame_clk = (c < 10);
                @(posedge clk_mclk);
                #1;
                if (resync_pulse) begin
                    count++;
                    if (count == 1) begin
                        first_edge = f;
                        lat = c;
                    end
                end
            end
        end
        frame_clk = 1'b0;
    endtask

    initial begin
        int fe, cnt, lat;
        // R1 reset state
        cycles(5);
        check("R1", "ready in reset", int'(ready), 0);
        check("R1", "pulse in reset", int'(resync_pulse), 0);
        rst = 1'b0;
        @(posedge clk_mclk);
        #1;
        check("R1", "ready after reset", int'(ready), 0);
        check("R1", "pulse after reset", int'(resync_pulse), 0);

        // R2 / R5: power-down held, bit clocks and frame edges ignored
        bclk_pulses(10);
        run_frames(128, 50, -40, 4, fe, cnt, lat);
        check("R2", "ready while powered down", int'(ready), 0);
        check("R5", "pulses while not ready", cnt, 0);

        // R3: partial count, then restart on a new release
        power_down = 1'b0;
        bclk_pulses(5);
        power_down = 1'b1;
        cycles(2);
        power_down = 1'b0;
        bclk_pulses(7);
        cycles(6);
        check("R3", "count restarted after release", int'(ready), 0);
        bclk_pulses(1);
        cycles(6);
        check("R3", "ready after 8 edges since release", int'(ready), 1);

        // R2: power-down clears ready after one edge
        @(negedge clk_mclk) power_down = 1'b1;
        @(posedge clk_mclk);
        #1;
        check("R2", "ready one edge after power-down", int'(ready), 0);

        // Vector table: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            int per;
            per = 128 * (int'(VECS[v].sel) + 1);
            bring_up(VECS[v].sel);
            run_frames(per, VECS[v].ka, VECS[v].kb, VECS[v].frames, fe, cnt, lat);
            check("R6", $sformatf("vec %0d first pulse edge", v), fe, VECS[v].exp_first);
            check("R7", $sformatf("vec %0d pulse count", v), cnt, VECS[v].exp_count);
            check("R8", $sformatf("vec %0d ready kept", v), int'(ready), 1);
            if (VECS[v].exp_count > 0)
                check("R9", $sformatf("vec %0d pulse latency", v), lat, 2);
        end

        // R4: ratio change after ready is ignored (frames stay 128 long)
        bring_up(2'b00);
        ratio_sel = 2'b11;
        run_frames(128, 0, 0, 10, fe, cnt, lat);
        check("R4", "ratio frozen after ready", cnt, 0);
        check("R5", "first edge only references", fe, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end
endmodule